// File: doc/BRIEF.md
# LCD Vertical Frame Timing Generator

This block produces the vertical timing of an LCD panel, one line period at a time. A separate horizontal timing block supplies a single-clock line-tick strobe; every tick ends the current line period and starts the next. On each tick the block steps through a fixed frame sequence. The sequence is an optional wait at the start of the frame, then the display lines, then an optional wait at the end of the frame, and last a sync interval. After the sync interval the next frame begins at once. The line tick is never gated, so line periods keep running through the waits and the sync interval.

Two panel kinds are supported. In the active kind (thin-film transistor), the frame pin works as a vertical sync that is asserted only after the end wait has run out. In the passive kind (super-twisted nematic), both waits count as zero. The frame pin then marks the first display line, and the sync-width field only adds extra idle line periods at the end of the frame. All fields are captured at the start of each frame, so values written during a frame take effect in the next frame.

The sequencer has five named states. IDLE means disabled, or enabled and waiting for the first tick. BEGIN_WAIT counts the start-of-frame wait. DISPLAY counts the display lines. END_WAIT counts the end-of-frame wait. SYNC counts the sync or extra-line periods. The transitions are: IDLE to BEGIN_WAIT (or to DISPLAY when the effective begin wait is zero) on the first tick; BEGIN_WAIT to DISPLAY after the wait; DISPLAY to END_WAIT (or to SYNC when the effective end wait is zero) after the last line; END_WAIT to SYNC after the wait; SYNC back to BEGIN_WAIT or DISPLAY when the next frame opens. Dropping the enable forces IDLE from any state.

Top module: `vframe_timer`

## Requirements
- R1: While `enable` is low, the sequencer is in IDLE and `frame_pin`, `line_active`, `line_idx`, `frame_start` and `frame_end` are all 0, even if ticks arrive. With `enable` high, the first `line_tick` opens a frame.
- R2: `frame_start` is high for exactly one clock, the clock after the tick that opens a frame. All configuration inputs are captured at that tick, and changes made later in the frame affect only the next frame.
- R3: With `tft_mode`=1 (active), the frame opens with `bof_wait` line periods (0 to 255) before the first display line.
- R4: Each frame has `panel_lines`+1 display line periods. During them `line_active` is 1 and `line_idx` counts 0, 1, …, `panel_lines`. Outside them `line_active` and `line_idx` are 0.
- R5: With `tft_mode`=1, `eof_wait` line periods (0 to 255) follow the last display line.
- R6: With `tft_mode`=1, `frame_pin` is high for exactly `sync_len`+1 line periods, those right after the end wait, and is low for the rest of the frame.
- R7: With `tft_mode`=0 (passive), `bof_wait` and `eof_wait` have no effect: the first line period of the frame is a display line, and the sync periods follow the last display line at once.
- R8: With `tft_mode`=0, `sync_len`+1 extra line periods follow the display lines. `frame_pin` is high only during the first display line (`line_idx`=0), whatever `sync_len` holds.
- R9: `frame_end` is high for one clock, the clock after the tick that starts the last line period of the frame. The next tick opens the following frame with no idle period in between.
- R10: Outputs change only in the clock after a `line_tick`. Between ticks, every output holds its value, except `frame_start` and `frame_end`, which return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run enable; low forces the sequencer to IDLE |
| line_tick | input | 1 | One-clock strobe marking each line period boundary |
| tft_mode | input | 1 | 1 = active panel, 0 = passive panel |
| bof_wait | input | 8 | Start-of-frame wait in line periods (active only) |
| eof_wait | input | 8 | End-of-frame wait in line periods (active only) |
| sync_len | input | 6 | Sync or extra-line count, minus one |
| panel_lines | input | 10 | Display lines per frame, minus one |
| frame_pin | output | 1 | Vertical sync (active) or first-line marker (passive) |
| line_active | output | 1 | High during display line periods |
| line_idx | output | 10 | Display line index, 0 outside display lines |
| frame_start | output | 1 | One-clock pulse when a frame opens |
| frame_end | output | 1 | One-clock pulse when the last line period of a frame starts |

## Verification
The block is built with its default field widths. The sweep keeps every field small: begin wait 0, 1 and 3; end wait 0 and 2; sync count 0 and 2; panel lines 0 and 3; each combination in both panel kinds. With these values every zero-length phase skip, every single-period phase and every phase-to-phase transition is reached within a few dozen line periods. The expected period position of each output is worked out from the frame length sum. Separate sequences cover a configuration change in the middle of a frame (including a begin wait that passive mode must ignore) and a drop of the enable in the middle of a frame with ticks still arriving.

// File: rtl/vft_pkg.sv
package vft_pkg;

    localparam int BOF_W  = 8;
    localparam int EOF_W  = 8;
    localparam int SYNC_W = 6;
    localparam int LINE_W = 10;

    localparam int WAIT_W = (BOF_W > EOF_W) ? BOF_W : EOF_W;
    localparam int PART_W = (WAIT_W > SYNC_W) ? WAIT_W : SYNC_W;
    localparam int CNT_W  = (PART_W > LINE_W) ? PART_W : LINE_W;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_BWAIT = 3'd1,
        PH_DISP  = 3'd2,
        PH_EWAIT = 3'd3,
        PH_SYNC  = 3'd4
    } phase_t;

    typedef struct packed {
        logic              tft;
        logic [BOF_W-1:0]  bof;
        logic [EOF_W-1:0]  eof;
        logic [SYNC_W-1:0] sync;
        logic [LINE_W-1:0] lines;
    } vcfg_t;

endpackage

// File: rtl/vft_shadow.sv
module vft_shadow
    import vft_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              tft_in,
    input  logic [BOF_W-1:0]  bof_in,
    input  logic [EOF_W-1:0]  eof_in,
    input  logic [SYNC_W-1:0] sync_in,
    input  logic [LINE_W-1:0] lines_in,
    output logic              live_bwait,
    output vcfg_t             held
);

    vcfg_t live;

    // Passive panels never wait at either end of the frame.
    always_comb begin
        live.tft   = tft_in;
        live.bof   = tft_in ? bof_in : '0;
        live.eof   = tft_in ? eof_in : '0;
        live.sync  = sync_in;
        live.lines = lines_in;
    end

    assign live_bwait = (live.bof != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
        end else if (load) begin
            held <= live;
        end
    end

endmodule

// File: rtl/vft_seq.sv
module vft_seq
    import vft_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              line_tick,
    input  logic              live_bwait,
    input  logic [BOF_W-1:0]  h_bof,
    input  logic [EOF_W-1:0]  h_eof,
    input  logic [SYNC_W-1:0] h_sync,
    input  logic [LINE_W-1:0] h_lines,
    input  logic              h_tft,
    output phase_t            ph,
    output logic [CNT_W-1:0]  cnt,
    output logic              open_frame,
    output logic              close_frame
);

    phase_t           ph_nxt;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] cnt_inc;
    logic             step;

    assign step    = enable && line_tick;
    assign cnt_inc = cnt + 1'b1;

    // Next-state process: moves only on a line tick.
    always_comb begin
        ph_nxt     = ph;
        cnt_nxt    = cnt;
        open_frame = 1'b0;
        if (!enable) begin
            ph_nxt  = PH_IDLE;
            cnt_nxt = '0;
        end else if (line_tick) begin
            unique case (ph)
                PH_IDLE: begin
                    open_frame = 1'b1;
                    ph_nxt     = live_bwait ? PH_BWAIT : PH_DISP;
                    cnt_nxt    = '0;
                end
                PH_BWAIT: begin
                    if (cnt_inc == CNT_W'(h_bof)) begin
                        ph_nxt  = PH_DISP;
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt_inc;
                    end
                end
                PH_DISP: begin
                    if (cnt == CNT_W'(h_lines)) begin
                        ph_nxt  = (h_eof != '0) ? PH_EWAIT : PH_SYNC;
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt_inc;
                    end
                end
                PH_EWAIT: begin
                    if (cnt_inc == CNT_W'(h_eof)) begin
                        ph_nxt  = PH_SYNC;
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt_inc;
                    end
                end
                PH_SYNC: begin
                    if (cnt == CNT_W'(h_sync)) begin
                        open_frame = 1'b1;
                        ph_nxt     = live_bwait ? PH_BWAIT : PH_DISP;
                        cnt_nxt    = '0;
                    end else begin
                        cnt_nxt = cnt_inc;
                    end
                end
                default: begin
                    ph_nxt  = PH_IDLE;
                    cnt_nxt = '0;
                end
            endcase
        end
    end

    // The last period of a frame is the final sync period.
    assign close_frame = step && !open_frame && (ph_nxt == PH_SYNC) &&
                         (cnt_nxt == CNT_W'(h_sync));

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else begin
            ph  <= ph_nxt;
            cnt <= cnt_nxt;
        end
    end

    p_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (ph == PH_IDLE) && (cnt == '0));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !line_tick) |=> ($stable(ph) && $stable(cnt)));

    p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_DISP) |-> (cnt <= CNT_W'(h_lines)));

    p_no_wait_passive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ph == PH_BWAIT) || (ph == PH_EWAIT)) |-> h_tft);

    p_sync_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_SYNC) |-> (cnt <= CNT_W'(h_sync)));

endmodule

// File: rtl/vft_drive.sv
module vft_drive
    import vft_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              line_tick,
    input  phase_t            ph,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              h_tft,
    input  logic              open_frame,
    input  logic              close_frame,
    output logic              frame_pin,
    output logic              line_active,
    output logic [LINE_W-1:0] line_idx,
    output logic              frame_start,
    output logic              frame_end
);

    // Level outputs decoded from the registered phase.
    always_comb begin
        line_active = 1'b0;
        line_idx    = '0;
        frame_pin   = 1'b0;
        unique case (ph)
            PH_DISP: begin
                line_active = 1'b1;
                line_idx    = cnt[LINE_W-1:0];
                frame_pin   = !h_tft && (cnt == '0);
            end
            PH_SYNC:  frame_pin = h_tft;
            PH_IDLE, PH_BWAIT, PH_EWAIT: frame_pin = 1'b0;
            default:  frame_pin = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_start <= 1'b0;
            frame_end   <= 1'b0;
        end else begin
            frame_start <= open_frame;
            frame_end   <= close_frame;
        end
    end

    p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_start && frame_end));

    p_end_then_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && enable && line_tick) |=> frame_start);

    p_first_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_active) |-> (line_idx == '0));

    p_vsync_off_lines_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pin && h_tft) |-> !line_active);

    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!frame_pin && !line_active && !frame_start && !frame_end));

endmodule

// File: rtl/vframe_timer.sv
module vframe_timer
    import vft_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              line_tick,
    input  logic              tft_mode,
    input  logic [BOF_W-1:0]  bof_wait,
    input  logic [EOF_W-1:0]  eof_wait,
    input  logic [SYNC_W-1:0] sync_len,
    input  logic [LINE_W-1:0] panel_lines,
    output logic              frame_pin,
    output logic              line_active,
    output logic [LINE_W-1:0] line_idx,
    output logic              frame_start,
    output logic              frame_end
);

    vcfg_t            hcfg;
    logic             live_bwait;
    phase_t           ph;
    logic [CNT_W-1:0] cnt;
    logic             open_frame;
    logic             close_frame;

    vft_shadow u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (open_frame),
        .tft_in     (tft_mode),
        .bof_in     (bof_wait),
        .eof_in     (eof_wait),
        .sync_in    (sync_len),
        .lines_in   (panel_lines),
        .live_bwait (live_bwait),
        .held       (hcfg)
    );

    vft_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .line_tick   (line_tick),
        .live_bwait  (live_bwait),
        .h_bof       (hcfg.bof),
        .h_eof       (hcfg.eof),
        .h_sync      (hcfg.sync),
        .h_lines     (hcfg.lines),
        .h_tft       (hcfg.tft),
        .ph          (ph),
        .cnt         (cnt),
        .open_frame  (open_frame),
        .close_frame (close_frame)
    );

    vft_drive u_drive (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .line_tick   (line_tick),
        .ph          (ph),
        .cnt         (cnt),
        .h_tft       (hcfg.tft),
        .open_frame  (open_frame),
        .close_frame (close_frame),
        .frame_pin   (frame_pin),
        .line_active (line_active),
        .line_idx    (line_idx),
        .frame_start (frame_start),
        .frame_end   (frame_end)
    );

endmodule

// File: tb/test_vframe_timer.sv
module test_vframe_timer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       enable;
    logic       line_tick;
    logic       tft_mode;
    logic [7:0] bof_wait;
    logic [7:0] eof_wait;
    logic [5:0] sync_len;
    logic [9:0] panel_lines;
    logic       frame_pin;
    logic       line_active;
    logic [9:0] line_idx;
    logic       frame_start;
    logic       frame_end;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // Bench model of the running frame.
    int k = 0;
    int f_tft, f_b, f_n, f_e, f_s, f_len;

    always #10 clk = ~clk;

    vframe_timer i_vframe_timer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .line_tick(line_tick),
        .tft_mode(tft_mode), .bof_wait(bof_wait), .eof_wait(eof_wait),
        .sync_len(sync_len), .panel_lines(panel_lines),
        .frame_pin(frame_pin), .line_active(line_active), .line_idx(line_idx),
        .frame_start(frame_start), .frame_end(frame_end)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int cur_len();
        int b = tft_mode ? int'(bof_wait) : 0;
        int e = tft_mode ? int'(eof_wait) : 0;
        return b + int'(panel_lines) + 1 + e + int'(sync_len) + 1;
    endfunction

    task automatic chk_quiet(input string req);
        chk(req, "frame_pin", int'(frame_pin), 0);
        chk(req, "line_active", int'(line_active), 0);
        chk(req, "line_idx", int'(line_idx), 0);
        chk(req, "frame_start", int'(frame_start), 0);
        chk(req, "frame_end", int'(frame_end), 0);
    endtask

    // One line period: tick, check the new period, then check it holds.
    task automatic step();
        int    e_act, e_idx, e_pin;
        string tag, pin_tag;
        @(negedge clk) line_tick = 1'b1;
        if (k == 0) begin
            f_tft = int'(tft_mode);
            f_b   = tft_mode ? int'(bof_wait) : 0;
            f_e   = tft_mode ? int'(eof_wait) : 0;
            f_n   = int'(panel_lines) + 1;
            f_s   = int'(sync_len) + 1;
            f_len = f_b + f_n + f_e + f_s;
        end
        @(negedge clk) line_tick = 1'b0;
        e_act = (k >= f_b && k < f_b + f_n) ? 1 : 0;
        e_idx = e_act ? k - f_b : 0;
        if (f_tft != 0) begin
            e_pin   = (k >= f_b + f_n + f_e) ? 1 : 0;
            pin_tag = "R6";
        end else begin
            e_pin   = (k == 0) ? 1 : 0;
            pin_tag = "R8";
        end
        if (f_tft == 0)                     tag = "R7";
        else if (k < f_b)                   tag = "R3";
        else if (k >= f_b + f_n && k < f_b + f_n + f_e) tag = "R5";
        else                                tag = "R4";
        chk(tag, "line_active", int'(line_active), e_act);
        chk("R4", "line_idx", int'(line_idx), e_idx);
        chk(pin_tag, "frame_pin", int'(frame_pin), e_pin);
        chk("R2", "frame_start", int'(frame_start), (k == 0) ? 1 : 0);
        chk("R9", "frame_end", int'(frame_end), (k == f_len - 1) ? 1 : 0);
        @(negedge clk);
        chk("R10", "frame_start hold", int'(frame_start), 0);
        chk("R10", "frame_end hold", int'(frame_end), 0);
        chk("R10", "line_active hold", int'(line_active), e_act);
        chk("R10", "frame_pin hold", int'(frame_pin), e_pin);
        chk("R10", "line_idx hold", int'(line_idx), e_idx);
        k = (k + 1 == f_len) ? 0 : k + 1;
    endtask

    task automatic restart();
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk_quiet("R1");
        enable = 1'b1;
        k = 0;
    endtask

    initial begin
        int bofs[3] = '{0, 1, 3};
        int lenA;
        rst_n = 1'b0; enable = 1'b0; line_tick = 1'b0; tft_mode = 1'b1;
        bof_wait = '0; eof_wait = '0; sync_len = '0; panel_lines = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_quiet("R1");

        // Sweep of small configurations in both panel kinds.
        for (int m = 0; m < 2; m++)
            for (int bi = 0; bi < 3; bi++)
                for (int e = 0; e < 4; e += 2)
                    for (int s = 0; s < 4; s += 2)
                        for (int n = 0; n < 4; n += 3) begin
                            tft_mode = m[0]; bof_wait = 8'(bofs[bi]);
                            eof_wait = 8'(e); sync_len = 6'(s); panel_lines = 10'(n);
                            restart();
                            for (int t = 0; t < 2 * cur_len() + 1; t++) step();
                        end

        // R2: change in mid-frame applies only to the next frame.
        tft_mode = 1'b1; bof_wait = 8'd2; eof_wait = 8'd1; sync_len = 6'd1; panel_lines = 10'd3;
        restart();
        lenA = cur_len();
        for (int t = 0; t < 3; t++) step();
        tft_mode = 1'b0; bof_wait = 8'd5; eof_wait = 8'd4; sync_len = 6'd2; panel_lines = 10'd1;
        for (int t = 0; t < lenA - 3 + 2 * cur_len(); t++) step();

        // R1: enable dropped mid-frame, ticks still arriving.
        tft_mode = 1'b1; bof_wait = 8'd1; eof_wait = 8'd2; sync_len = 6'd0; panel_lines = 10'd2;
        restart();
        for (int t = 0; t < 3; t++) step();
        enable = 1'b0;
        @(negedge clk);
        chk_quiet("R1");
        @(negedge clk) line_tick = 1'b1;
        @(negedge clk) line_tick = 1'b0;
        chk_quiet("R1");
        enable = 1'b1;
        k = 0;
        for (int t = 0; t < cur_len() + 1; t++) step();

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule